// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Flag

This unit computes signed saturating sums and differences of two operand words. It has four operations: plain add, plain subtract, and two doubling forms. In a doubling form, the second operand is first doubled with saturation, and then added to or subtracted from the first operand with a second saturation. Any result that cannot be represented is clamped to the nearest representable signed value.

A sticky flag records that some accepted operation saturated at either stage. Later operations cannot clear it. It changes back only through the dedicated flag write port, which can also set it. The result and the flag are registered. A result appears one clock after the strobe that carried its operands, together with a one-cycle valid pulse.

Top module: `sat_arith_unit`

## Requirements
- R1: While reset is active and on the first cycle after it, `out_valid` is 0, `result` is 0 and `sticky` is 0.
- R2: With `op_sel` = 0 and `in_valid` high, `result` becomes SAT(`opnd_m` + `opnd_n`) one clock later.
- R3: With `op_sel` = 1 and `in_valid` high, `result` becomes SAT(`opnd_m` − `opnd_n`) one clock later.
- R4: With `op_sel` = 2 and `in_valid` high, `result` becomes SAT(`opnd_m` + SAT(2·`opnd_n`)) one clock later.
- R5: With `op_sel` = 3 and `in_valid` high, `result` becomes SAT(`opnd_m` − SAT(2·`opnd_n`)) one clock later.
- R6: Saturation gives 0x7FFFFFFF for a positive overflow and 0x80000000 for a negative overflow. Operands and results are two's complement.
- R7: An accepted operation that saturates at any stage sets `sticky` on the next clock. This includes the doubling step alone, when the final step does not saturate.
- R8: An operation that does not saturate leaves `sticky` unchanged.
- R9: When `flag_wr` is high, `sticky` takes `flag_wdata` on the next clock. This write takes priority over a saturation in the same cycle.
- R10: `out_valid` is high for exactly the clocks that follow a cycle with `in_valid` high. Back-to-back strobes give back-to-back results.
- R11: When `in_valid` is low, the operands are ignored. `out_valid` is 0, `result` keeps its last value, and `sticky` does not change, however large the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and operation are accepted on this clock |
| op_sel | input | 2 | 0 add, 1 subtract, 2 doubling add, 3 doubling subtract |
| opnd_m | input | 32 | First operand, signed |
| opnd_n | input | 32 | Second operand, signed (the one that is doubled) |
| flag_wr | input | 1 | Write strobe for the sticky flag |
| flag_wdata | input | 1 | Value written to the sticky flag |
| out_valid | output | 1 | Result valid pulse |
| result | output | 32 | Saturated result, held between operations |
| sticky | output | 1 | Sticky saturation flag |

## Verification
The bench targets the doubling operand whose two top bits differ. In this case only the doubling step saturates, while the final sum fits. A design that checks only the final step would leave the flag clear, and one that skips the first clamp would return a wrapped value.

Exact edge operands are also tested:
- A sum that reaches 0x7FFFFFFF without passing it.
- A difference against 0x80000000.

Getting the clamp direction or the overflow test wrong shows up as a value off by sign, or as a spurious flag.

Further cases:
- A flag write in the same cycle as an overflow. A design with the wrong priority leaves the flag set.
- Large operands with the strobe low. A design that ignores the strobe would set the flag or change the held result.

// File: rtl/sat_pkg.sv
package sat_pkg;

  typedef enum logic [1:0] {
    SAT_ADD  = 2'd0,
    SAT_SUB  = 2'd1,
    SAT_DADD = 2'd2,
    SAT_DSUB = 2'd3
  } sat_op_e;

  function automatic logic op_subtracts(input sat_op_e op);
    return (op == SAT_SUB) || (op == SAT_DSUB);
  endfunction

  function automatic logic op_doubles(input sat_op_e op);
    return (op == SAT_DADD) || (op == SAT_DSUB);
  endfunction

endpackage

// File: rtl/sat_doubler.sv
module sat_doubler #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] dbl_o,
  output logic         sat_o
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  // Doubling overflows exactly when the two top bits disagree.
  function automatic logic dbl_overflows(input logic [W-1:0] v);
    return v[W-1] ^ v[W-2];
  endfunction

  function automatic logic [W-1:0] dbl_clamp(input logic [W-1:0] v);
    if (dbl_overflows(v)) return v[W-1] ? MINV : MAXV;
    return {v[W-2:0], 1'b0};
  endfunction

  always_comb begin
    sat_o = dbl_overflows(val_i);
    dbl_o = dbl_clamp(val_i);
  end

  // The sign of the operand survives doubling in every case (R4).
  always_comb begin
    if (!$isunknown(val_i)) begin
      assert_dbl_sign_R4: assert (dbl_o[W-1] == val_i[W-1]);
    end
  end

endmodule

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         sat_o
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  // One guard bit is enough to see a signed overflow.
  function automatic logic [W:0] wide_sum(input logic [W-1:0] a,
                                          input logic [W-1:0] b,
                                          input logic         sub);
    logic [W:0] ax, bx;
    ax = {a[W-1], a};
    bx = {b[W-1], b};
    return sub ? (ax - bx) : (ax + bx);
  endfunction

  function automatic logic [W-1:0] clamp_wide(input logic [W:0] s);
    if (s[W] != s[W-1]) return s[W] ? MINV : MAXV;
    return s[W-1:0];
  endfunction

  logic [W:0] sum_w;

  always_comb begin
    sum_w = wide_sum(a_i, b_i, sub_i);
    sat_o = sum_w[W] ^ sum_w[W-1];
    res_o = clamp_wide(sum_w);
  end

  // A saturated output must be one of the two clamp values (R6).
  always_comb begin
    if (sat_o === 1'b1) begin
      assert_clamp_R6: assert ((res_o == MAXV) || (res_o == MINV));
    end
  end

endmodule

// File: rtl/sat_sticky.sv
module sat_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic set_i,
  output logic flag_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (wr_i)  flag_q <= wdata_i;
    else            flag_q <= flag_q | set_i;
  end

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !set_i) |=> $stable(flag_q));

  assert_sticky_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !wr_i) |=> flag_q);

  assert_flag_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (flag_q == $past(wdata_i)));

endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   op_sel,
  input  logic [W-1:0] opnd_m,
  input  logic [W-1:0] opnd_n,
  input  logic         flag_wr,
  input  logic         flag_wdata,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         sticky
);
  import sat_pkg::*;

  sat_op_e      op;
  logic         do_sub, do_dbl;
  logic [W-1:0] dbl_val, rhs_val, stage_res;
  logic         dbl_sat, stage_sat;
  logic         sat_event;  // an accepted operation saturated somewhere

  always_comb begin
    op     = sat_op_e'(op_sel);
    do_sub = op_subtracts(op);
    do_dbl = op_doubles(op);
  end

  sat_doubler #(.W(W)) u_dbl (
    .val_i (opnd_n),
    .dbl_o (dbl_val),
    .sat_o (dbl_sat)
  );

  assign rhs_val = do_dbl ? dbl_val : opnd_n;

  sat_addsub #(.W(W)) u_as (
    .a_i   (opnd_m),
    .b_i   (rhs_val),
    .sub_i (do_sub),
    .res_o (stage_res),
    .sat_o (stage_sat)
  );

  assign sat_event = in_valid & (stage_sat | (do_dbl & dbl_sat));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= stage_res;
    end
  end

  sat_sticky u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (flag_wr),
    .wdata_i (flag_wdata),
    .set_i   (sat_event),
    .flag_q  (sticky)
  );

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));

endmodule

// File: tb/sat_arith_unit_bench.sv
module sat_arith_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = 2'd0;
  logic [31:0] opnd_m = '0, opnd_n = '0;
  logic        flag_wr = 1'b0, flag_wdata = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        sticky;

  always #2.5 clk = ~clk;

  sat_arith_unit u_sat_arith_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .opnd_m(opnd_m), .opnd_n(opnd_n), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .out_valid(out_valid), .result(result),
    .sticky(sticky)
  );

  typedef struct {
    logic        vld;
    logic [31:0] res;
    logic        flg;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0, n_bad = 0;
  logic [31:0] m_res = '0;
  logic        m_flg = 1'b0;
  bit          done = 0;

  localparam longint MAXL = 64'sd2147483647;
  localparam longint MINL = -64'sd2147483648;

  // Reference model written with wide integers, independent of bit tricks.
  task automatic ref_op(input logic [1:0] op, input logic [31:0] m,
                        input logic [31:0] n, output logic [31:0] r,
                        output logic ovf);
    longint mm, nn, s;
    mm  = longint'($signed(m));
    nn  = longint'($signed(n));
    ovf = 1'b0;
    if (op[1]) begin
      nn = nn * 2;
      if (nn > MAXL) begin nn = MAXL; ovf = 1'b1; end
      if (nn < MINL) begin nn = MINL; ovf = 1'b1; end
    end
    s = op[0] ? (mm - nn) : (mm + nn);
    if (s > MAXL) begin s = MAXL; ovf = 1'b1; end
    if (s < MINL) begin s = MINL; ovf = 1'b1; end
    r = s[31:0];
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One clock of stimulus; called and returning on a falling edge.
  task automatic cyc(input logic v, input logic [1:0] op, input logic [31:0] m,
                     input logic [31:0] n, input logic wr, input logic wd,
                     input string tag);
    logic [31:0] r;
    logic        ovf;
    exp_t        e;
    in_valid = v; op_sel = op; opnd_m = m; opnd_n = n;
    flag_wr = wr; flag_wdata = wd;
    @(posedge clk);
    ref_op(op, m, n, r, ovf);
    if (v) m_res = r;
    if (wr) m_flg = wd;
    else if (v && ovf) m_flg = 1'b1;
    e.vld = v; e.res = m_res; e.flg = m_flg; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b0; flag_wr = 1'b0;
  endtask

  // Monitor: compare every produced cycle against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(out_valid == e.vld, e.tag, "out_valid", {31'd0, out_valid}, {31'd0, e.vld});
        check(result == e.res, e.tag, "result", result, e.res);
        check(sticky == e.flg, e.tag, "sticky", {31'd0, sticky}, {31'd0, e.flg});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    // R1: reset state while in reset and right after release
    check(out_valid == 1'b0, "R1", "out_valid", {31'd0, out_valid}, 32'd0);
    check(result == 32'd0, "R1", "result", result, 32'd0);
    check(sticky == 1'b0, "R1", "sticky", {31'd0, sticky}, 32'd0);
    rst_n = 1'b1;
    cyc(0, 2'd0, 32'd0, 32'd0, 0, 0, "R1");

    cyc(1, 2'd0, 32'd1, 32'd2, 0, 0, "R2");
    cyc(1, 2'd0, 32'h7FFF_FFFE, 32'd1, 0, 0, "R2");          // exactly max, no flag
    cyc(1, 2'd0, 32'h7FFF_FFFF, 32'd1, 0, 0, "R6");          // positive clamp, flag set
    cyc(1, 2'd0, 32'd5, 32'd6, 0, 0, "R8");                  // flag stays set
    cyc(0, 2'd0, 32'd0, 32'd0, 1, 0, "R9");                  // clear by write
    cyc(1, 2'd1, 32'd5, 32'd7, 0, 0, "R3");
    cyc(1, 2'd1, 32'h8000_0000, 32'd1, 0, 0, "R6");          // negative clamp
    cyc(0, 2'd0, 32'd0, 32'd0, 1, 0, "R9");
    cyc(0, 2'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, "R11"); // ignored
    cyc(0, 2'd3, 32'h8000_0000, 32'h4000_0000, 0, 0, "R11");
    cyc(1, 2'd2, 32'd1, 32'd3, 0, 0, "R4");
    cyc(1, 2'd2, 32'h8000_0000, 32'h4000_0000, 0, 0, "R7"); // only doubling saturates
    cyc(0, 2'd0, 32'd0, 32'd0, 1, 0, "R9");
    cyc(1, 2'd3, 32'd10, 32'd2, 0, 0, "R5");
    cyc(1, 2'd3, 32'd0, 32'hC000_0000, 0, 0, "R5");         // final step saturates
    cyc(0, 2'd0, 32'd0, 32'd0, 1, 0, "R9");
    cyc(1, 2'd3, 32'hFFFF_FFFF, 32'h8000_0000, 0, 0, "R7"); // doubling step only
    cyc(1, 2'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 0, "R9"); // write beats overflow
    cyc(0, 2'd0, 32'd0, 32'd0, 1, 1, "R9");                  // write sets
    cyc(1, 2'd1, 32'd3, 32'd3, 0, 0, "R8");
    cyc(0, 2'd0, 32'd0, 32'd0, 1, 0, "R9");
    a = 32'h1234_5678; b = 32'h9E37_79B9;
    for (int i = 0; i < 48; i++) begin
      a = a * 32'd1103515245 + 32'd12345;
      b = {b[30:0], b[31] ^ b[21] ^ b[1] ^ b[0]};
      cyc(1, 2'(i), a, b, 0, 0, "R10");                      // back-to-back
      if (i % 12 == 11) cyc(0, 2'd0, a, b, 1, 0, "R11");
    end
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule